// File: doc/BRIEF.md
# GPIO Port with Peripheral Overrides

This block is an 8-bit general-purpose I/O port for one group of chip pads. Software reaches it over a simple register bus. Through that bus it writes an output data latch, a per-pin direction register and a per-pin pull-device enable register, and it reads back pad values. An LCD segment driver and a PWM module can each take over individual pins. They do this through per-pin enable inputs, and the stored direction bits are never rewritten. The most significant pin also has a PWM shutdown input, which forces that pin to be an input.

The effective state of each pin is resolved by a fixed priority. An LCD enable comes first and turns off both pad buffers and the pull device. PWM shutdown comes next, on the top pin only, and forces input. A PWM channel enable comes next and forces output, driving the pin from the PWM channel level. The software direction bit applies only when none of these is active. Pad inputs pass through a two-flop synchronizer before software can read them. The block drives the output-enable, input-enable, pull-enable and output-level signals to the pads.

Top module: `gpio_port_ovr`

## Requirements
- R1: After synchronous reset the direction register and data latch read 0x00 and the pull register reads 0xFF. Every pad output enable is 0, and every input enable and pull enable is 1.
- R2: When the LCD enable of a pin is 1, that pin's output enable, input enable and pull enable are all 0. Its bit in the input register reads 0 from the third clock edge on. This holds whatever the direction bit, PWM enable or shutdown input is.
- R3: When the LCD enable is 0 and the PWM enable of a pin is 1, the output enable is 1 and the pad output level equals that pin's PWM level. The exception is the top pin while shutdown is 1.
- R4: While PWM shutdown is 1 and the top pin's LCD enable is 0, the top pin has output enable 0 and input enable 1. This applies even when its PWM enable is 1.
- R5: Overrides never change the stored direction register. Reading the direction register (address 2) returns the last value written, whatever the override inputs are.
- R6: A change on a pad input shows up in the input register (address 1) after exactly two rising clock edges, and not after one.
- R7: Reading the data register (address 0) returns the data latch bit for pins whose effective output enable is 1, and the synchronized pad value for the other pins. Pins with no PWM drive put the latch bit on the pad output.
- R8: The reserved location (address 3) always reads 0x00, and writes to it change no other register.
- R9: The pull register (address 4) is read/write. A pin's pad pull enable equals its pull bit, forced to 0 when its effective output enable is 1 or its LCD enable is 1.
- R10: Addresses 5 to 7 read 0x00, and writes to the input register or to them change nothing. Writes take effect at the clock edge where the write strobe is 1, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 8 | Raw pad input levels |
| lcd_en | input | 8 | Per-pin LCD segment enable |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_lvl | input | 8 | Per-pin PWM channel output level |
| pwm_shdn | input | 1 | PWM shutdown, acts on the top pin |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output enable |
| pad_ie | output | 8 | Pad input enable |
| pad_pe | output | 8 | Pad pull-device enable |

## Verification
The bench applies conflicting overrides at the same time, such as LCD with PWM, shutdown with PWM on the top pin, and PWM against a direction bit of 0. A design with the priority in the wrong order would drive a pad that should float, or would leave the shutdown pin driven. After every override pattern it reads back the direction register, which catches a design that writes an override into the stored bits. It samples the input register one edge and two edges after a pad change, which catches a synchronizer with the wrong depth. It also mixes latch and pad bits in a data read, and it writes to the reserved and unmapped addresses, which catches address decode that aliases onto a real register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPINS  = 8;
    localparam int AW     = 3;
    localparam int SYNC_N = 2;

    localparam logic [AW-1:0] A_DATA = 3'd0;
    localparam logic [AW-1:0] A_INP  = 3'd1;
    localparam logic [AW-1:0] A_DIR  = 3'd2;
    localparam logic [AW-1:0] A_RSV  = 3'd3;
    localparam logic [AW-1:0] A_PULL = 3'd4;

    typedef enum logic [1:0] {
        PM_SW     = 2'd0,
        PM_PWM    = 2'd1,
        PM_SHDN   = 2'd2,
        PM_LCDOFF = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic ie;
        logic pe;
        logic out;
    } pin_drv_t;

    function automatic pin_mode_e pick_mode(input logic lcd, input logic sd,
                                            input logic pwm);
        if (lcd)      return PM_LCDOFF;
        else if (sd)  return PM_SHDN;
        else if (pwm) return PM_PWM;
        else          return PM_SW;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int N = NPINS,
    parameter int SD_PIN = NPINS - 1
) (
    input  logic [N-1:0] dir,
    input  logic [N-1:0] latch,
    input  logic [N-1:0] pull,
    input  logic [N-1:0] lcd_en,
    input  logic [N-1:0] pwm_en,
    input  logic [N-1:0] pwm_lvl,
    input  logic         pwm_shdn,
    output logic [N-1:0] oe,
    output logic [N-1:0] ie,
    output logic [N-1:0] pe,
    output logic [N-1:0] out
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_mode_e mode;
        pin_drv_t  drv;
        logic      sd_here;

        if (i == SD_PIN) begin : g_sd
            assign sd_here = pwm_shdn;
        end else begin : g_nosd
            assign sd_here = 1'b0;
        end

        assign mode = pick_mode(lcd_en[i], sd_here, pwm_en[i]);

        always_comb begin
            drv.out = latch[i];
            case (mode)
                PM_LCDOFF: begin
                    drv.oe = 1'b0; drv.ie = 1'b0; drv.pe = 1'b0;
                end
                PM_SHDN: begin
                    drv.oe = 1'b0; drv.ie = 1'b1; drv.pe = pull[i];
                end
                PM_PWM: begin
                    drv.oe = 1'b1; drv.ie = 1'b1; drv.pe = 1'b0;
                    drv.out = pwm_lvl[i];
                end
                default: begin
                    drv.oe = dir[i]; drv.ie = 1'b1;
                    drv.pe = pull[i] & ~dir[i];
                end
            endcase
        end

        assign oe[i]  = drv.oe;
        assign ie[i]  = drv.ie;
        assign pe[i]  = drv.pe;
        assign out[i] = drv.out;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  sync_in,
    input  logic [N-1:0]  eff_oe,
    output logic [N-1:0]  rdata,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  data_q,
    output logic [N-1:0]  pull_q
);
    logic wr_data, wr_dir, wr_pull;

    assign wr_data = wr && (addr == A_DATA);
    assign wr_dir  = wr && (addr == A_DIR);
    assign wr_pull = wr && (addr == A_PULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '1;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_dir)  dir_q  <= wdata;
            if (wr_pull) pull_q <= wdata;
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = (data_q & eff_oe) | (sync_in & ~eff_oe);
            A_INP:   rdata = sync_in;
            A_DIR:   rdata = dir_q;
            A_PULL:  rdata = pull_q;
            default: rdata = '0;
        endcase
    end

    // R5: the direction bits move only on a direction write
    p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_dir) |-> $stable(dir_q));

    // R8, R10: writes to the reserved or unmapped locations leave every register as it was
    p_rsv_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && addr >= A_RSV && addr != A_PULL) |=>
        ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  pad_in,
    input  logic [N-1:0]  lcd_en,
    input  logic [N-1:0]  pwm_en,
    input  logic [N-1:0]  pwm_lvl,
    input  logic          pwm_shdn,
    output logic [N-1:0]  pad_out,
    output logic [N-1:0]  pad_oe,
    output logic [N-1:0]  pad_ie,
    output logic [N-1:0]  pad_pe
);
    localparam int TOP = N - 1;

    logic [N-1:0] dir_q, data_q, pull_q, sync_q, gated_in;

    assign gated_in = pad_in & pad_ie;

    gpio_sync #(.W(N), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d(gated_in), .q(sync_q)
    );

    gpio_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .sync_in(sync_q), .eff_oe(pad_oe),
        .rdata(bus_rdata), .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q)
    );

    gpio_pin_ctrl #(.N(N), .SD_PIN(TOP)) u_pins (
        .dir(dir_q), .latch(data_q), .pull(pull_q),
        .lcd_en(lcd_en), .pwm_en(pwm_en), .pwm_lvl(pwm_lvl),
        .pwm_shdn(pwm_shdn),
        .oe(pad_oe), .ie(pad_ie), .pe(pad_pe), .out(pad_out)
    );

    // R2: an LCD-owned pin has every pad buffer off
    p_lcd_off_r2: assert property (@(posedge clk) disable iff (rst)
        ((lcd_en & (pad_oe | pad_ie | pad_pe)) == '0));

    // R3: PWM-owned pins drive the PWM level
    p_pwm_drive_r3: assert property (@(posedge clk) disable iff (rst)
        ((pwm_en & ~lcd_en & ~({pwm_shdn, {(N-1){1'b0}}}) &
          (~pad_oe | (pad_out ^ pwm_lvl))) == '0));

    // R4: shutdown keeps the top pin an input
    p_shdn_input_r4: assert property (@(posedge clk) disable iff (rst)
        (pwm_shdn && !lcd_en[TOP]) |-> (!pad_oe[TOP] && pad_ie[TOP]));

    // R8: reserved location reads zero
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_RSV) |-> (bus_rdata == '0));

    // R9: no pull device on a driven pin
    p_pull_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ((pad_pe & pad_oe) == '0));
endmodule

// File: tb/gpio_port_ovr_test.sv
module gpio_port_ovr_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0, lcd_en = '0, pwm_en = '0, pwm_lvl = '0;
    logic       pwm_shdn = 1'b0;
    logic [7:0] pad_out, pad_oe, pad_ie, pad_pe;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    gpio_port_ovr uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .lcd_en(lcd_en), .pwm_en(pwm_en), .pwm_lvl(pwm_lvl),
        .pwm_shdn(pwm_shdn), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_ie(pad_ie), .pad_pe(pad_pe)
    );

    // lcd, pwm_en, pwm_lvl, shdn, dir | exp oe, ie, pe, out  (pull=FF, latch=0F)
    typedef struct packed {
        logic [7:0] lcd, pen, plv;
        logic       sd;
        logic [7:0] dir, oe, ie, pe, out;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 8'h00, 8'h00, 1'b0, 8'hF0, 8'hF0, 8'hFF, 8'h0F, 8'h0F},
        '{8'h0F, 8'h00, 8'h00, 1'b0, 8'hFF, 8'hF0, 8'hF0, 8'h00, 8'h0F},
        '{8'h00, 8'h81, 8'h80, 1'b0, 8'h00, 8'h81, 8'hFF, 8'h7E, 8'h8E},
        '{8'h00, 8'h81, 8'h81, 1'b1, 8'h00, 8'h01, 8'hFF, 8'hFE, 8'h0F},
        '{8'h80, 8'h80, 8'h80, 1'b1, 8'h80, 8'h00, 8'h7F, 8'h7F, 8'h0F},
        '{8'h00, 8'h00, 8'hFF, 1'b1, 8'h80, 8'h00, 8'hFF, 8'hFF, 8'h0F}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        #100000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(3'd2, v); chk("R1 dir", v, 8'h00);
        rd(3'd4, v); chk("R1 pull", v, 8'hFF);
        rd(3'd0, v); chk("R1 data", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 ie", pad_ie, 8'hFF);
        chk("R1 pe", pad_pe, 8'hFF);

        wr(3'd0, 8'h0F);
        for (int i = 0; i < NV; i++) begin
            wr(3'd2, VEC[i].dir);
            lcd_en = VEC[i].lcd; pwm_en = VEC[i].pen;
            pwm_lvl = VEC[i].plv; pwm_shdn = VEC[i].sd;
            #0.5;
            chk("R2/R3/R4 oe", pad_oe, VEC[i].oe);
            chk("R2/R4 ie", pad_ie, VEC[i].ie);
            chk("R9 pe", pad_pe, VEC[i].pe);
            chk("R3/R7 out", pad_out, VEC[i].out);
            rd(3'd2, v); chk("R5 dir kept", v, VEC[i].dir);
        end

        // R2: LCD pin input bit reads 0 even with pad high
        lcd_en = 8'h0F; pwm_en = '0; pwm_shdn = 1'b0; pad_in = 8'hFF;
        wr(3'd2, 8'h00);
        repeat (2) @(negedge clk);
        rd(3'd1, v); chk("R2 lcd input", v, 8'hF0);
        lcd_en = '0; pad_in = '0;
        repeat (3) @(negedge clk);

        // R6 two-edge latency
        pad_in = 8'hA5;
        @(negedge clk);
        rd(3'd1, v); chk("R6 one edge", v, 8'h00);
        @(negedge clk);
        rd(3'd1, v); chk("R6 two edges", v, 8'hA5);

        // R7 data read mixes latch and pad
        wr(3'd2, 8'hF0);
        rd(3'd0, v); chk("R7 mix", v, 8'h05);
        wr(3'd0, 8'h3C);
        rd(3'd0, v); chk("R7 mix2", v, 8'h35);

        // R8 reserved
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk("R8 rsv read", v, 8'h00);
        rd(3'd2, v); chk("R8 dir unchanged", v, 8'hF0);
        rd(3'd4, v); chk("R8 pull unchanged", v, 8'hFF);
        rd(3'd0, v); chk("R8 data unchanged", v, 8'h35);

        // R9 pull write
        wr(3'd4, 8'h5A);
        rd(3'd4, v); chk("R9 pull rd", v, 8'h5A);
        #0.5; chk("R9 pe gate", pad_pe, 8'h0A);

        // R10 unmapped and input writes
        wr(3'd5, 8'hFF);
        wr(3'd1, 8'h00);
        rd(3'd5, v); chk("R10 unmapped", v, 8'h00);
        rd(3'd7, v); chk("R10 unmapped7", v, 8'h00);
        rd(3'd1, v); chk("R10 input ro", v, 8'hA5);
        rd(3'd2, v); chk("R10 dir", v, 8'hF0);
        rd(3'd4, v); chk("R10 pull", v, 8'h5A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule